// File: doc/BRIEF.md
# Two-Operand Integer ALU with Condition Flags

This block is a purely combinational integer unit for a datapath. It takes two
operands of `WIDTH` bits (32 by default) and a two-bit operation code, and it
returns a result word with four condition flags. The flags are sign, zero,
carry-out and signed overflow. Addition and subtraction share one carry-propagate
adder. For subtraction the second operand is inverted and a carry-in of one is
injected, so the adder computes A + ~B + 1. A result selector then picks the
adder output or the bitwise AND or OR of the operands.

The carry and overflow flags describe the adder only. They read zero whenever
a logic operation is selected. The sign and zero flags always describe the
word on `result_o`. Outputs follow the inputs in the same cycle, so the block
sits between pipeline registers owned by the surrounding datapath. It has no
clock, no handshake and no state. The parameter `ADDER_KIND` picks the carry
structure: a log-depth parallel-prefix tree (the default) or a serial carry
chain. Both give the same function.

Top module: `nzcv_alu`

## Requirements
- R1: With `op_i` = 2'b00, `result_o` equals (A + B) modulo 2^WIDTH.
- R2: With `op_i` = 2'b01, `result_o` equals A + ~B + 1 modulo 2^WIDTH, which is A − B.
- R3: With `op_i` = 2'b10, `result_o` is the bitwise AND of A and B. With `op_i` = 2'b11, it is the bitwise OR.
- R4: `neg_o` equals bit WIDTH−1 of `result_o` for every operation.
- R5: `zero_o` is 1 exactly when every bit of `result_o` is 0, for every operation.
- R6: For add and subtract, `carry_o` is the carry out of the adder's top bit. For subtraction this is 1 exactly when A ≥ B as unsigned numbers.
- R7: With `op_i[1]` = 1 (AND, OR), `carry_o` and `ovf_o` are both 0, whatever the operands are.
- R8: For addition, `ovf_o` is 1 exactly when A and B have the same sign bit and the sum's sign bit differs from A's.
- R9: For subtraction, `ovf_o` is 1 exactly when A and B have different sign bits and the difference's sign bit differs from A's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| result_o | output | WIDTH | Selected result word |
| neg_o | output | 1 | Sign bit of the result |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Adder carry-out, arithmetic operations only |
| ovf_o | output | 1 | Signed overflow, arithmetic operations only |

## Verification
Each operation is driven with operand pairs chosen to separate the flags.

- Small positive values give the plain sums, with no flag raised.
- A carry that runs through every bit (all ones plus one) tells carry-out apart from overflow.
- The signed limits (0x7FFFFFFF + 1 and 0x80000000 − 1) raise overflow without carry, and then both together.
- Equal operands under subtraction show zero together with carry set, since there is no borrow.
- A smaller minus a larger unsigned value clears carry.
- The logic operations are applied to operands that would carry and overflow if added, so gating those two flags is observed at the ports.
- Every vector is compared with a model built on widened signed and unsigned arithmetic.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  localparam int unsigned ADDER_PREFIX = 0;
  localparam int unsigned ADDER_RIPPLE = 1;

endpackage

// File: rtl/nzcv_operand_prep.sv
module nzcv_operand_prep #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] b_i,
  input  logic         invert_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  // Two's-complement negation is split: invert here, +1 enters as carry-in.
  assign b_eff_o = b_i ^ {W{invert_i}};
  assign cin_o   = invert_i;
endmodule

// File: rtl/nzcv_adder.sv
module nzcv_adder #(
  parameter int unsigned W    = 32,
  parameter int unsigned KIND = 0
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] half;
  logic [W-1:0] cvec;
  logic         ctop;

  assign half = x_i ^ y_i;

  generate
    if (KIND == 0) begin : g_prefix
      // Parallel-prefix tree; carry-in folded into column 0 generate.
      logic [W-1:0] gg, pp, gn, pn;
      always_comb begin
        gg    = x_i & y_i;
        pp    = half;
        gg[0] = gg[0] | (pp[0] & cin_i);
        gn    = gg;
        pn    = pp;
        for (int l = 0; l < int'(LVL); l++) begin
          for (int i = 0; i < int'(W); i++) begin
            if (i >= (1 << l)) begin
              gn[i] = gg[i] | (pp[i] & gg[i - (1 << l)]);
              pn[i] = pp[i] & pp[i - (1 << l)];
            end else begin
              gn[i] = gg[i];
              pn[i] = pp[i];
            end
          end
          gg = gn;
          pp = pn;
        end
      end
      assign cvec = {gg[W-2:0], cin_i};
      assign ctop = gg[W-1];
    end else begin : g_ripple
      logic [W:0] chain;
      always_comb begin
        chain[0] = cin_i;
        for (int i = 0; i < int'(W); i++) begin
          chain[i+1] = (x_i[i] & y_i[i]) | (half[i] & chain[i]);
        end
      end
      assign cvec = chain[W-1:0];
      assign ctop = chain[W];
    end
  endgenerate

  assign sum_o  = half ^ cvec;
  assign cout_o = ctop;
endmodule

// File: rtl/nzcv_flag_unit.sv
module nzcv_flag_unit #(
  parameter int unsigned W = 32
) (
  input  logic [1:0]   op_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic         sum_msb_i,
  input  logic         cout_i,
  input  logic [W-1:0] result_i,
  output logic         neg_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic arith;
  logic sign_flip;
  logic sign_match;

  assign arith      = ~op_i[1];
  // Sum sign left A's sign.
  assign sign_flip  = a_msb_i ^ sum_msb_i;
  // Add: operands alike. Subtract: operands unlike.
  assign sign_match = ~(a_msb_i ^ b_msb_i ^ op_i[0]);

  assign neg_o   = result_i[W-1];
  assign zero_o  = ~|result_i;
  assign carry_o = arith & cout_i;
  assign ovf_o   = arith & sign_flip & sign_match;
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
  import nzcv_alu_pkg::*;
#(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned ADDER_KIND = ADDER_PREFIX
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum;
  logic             cout;

  assign op = alu_op_e'(op_i);

  nzcv_operand_prep #(.W(WIDTH)) u_prep (
    .b_i     (b_i),
    .invert_i(op_i[0]),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  nzcv_adder #(.W(WIDTH), .KIND(ADDER_KIND)) u_add (
    .x_i   (a_i),
    .y_i   (b_eff),
    .cin_i (cin),
    .sum_o (sum),
    .cout_o(cout)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = a_i & b_i;
      OP_OR:          result_o = a_i | b_i;
      default:        result_o = sum;
    endcase
  end

  nzcv_flag_unit #(.W(WIDTH)) u_flags (
    .op_i     (op_i),
    .a_msb_i  (a_i[MSB]),
    .b_msb_i  (b_i[MSB]),
    .sum_msb_i(sum[MSB]),
    .cout_i   (cout),
    .result_i (result_o),
    .neg_o    (neg_o),
    .zero_o   (zero_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/nzcv_alu_chk.sv
module nzcv_alu_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         ovf_o
);
  logic [W:0] wide_add;
  logic       add_ovf;

  always_comb begin
    wide_add = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    add_ovf  = wide_add[W] ^ wide_add[W-1];
    if (!$isunknown({a_i, b_i, op_i})) begin
      if (op_i == 2'b00) begin
        p_add_sum_r1: assert final (result_o == wide_add[W-1:0]);
        p_add_ovf_r8: assert final (ovf_o == add_ovf);
      end
      if (op_i == 2'b01) begin
        p_sub_diff_r2: assert final (result_o + b_i == a_i);
      end
      if (op_i == 2'b10) begin
        p_and_word_r3: assert final ((result_o & ~a_i) == '0 && (result_o & ~b_i) == '0);
      end
      if (op_i[1]) begin
        p_no_arith_flags_r7: assert final (!carry_o && !ovf_o);
      end
    end
  end
endmodule

bind nzcv_alu nzcv_alu_chk #(.W(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .result_o(result_o),
  .carry_o (carry_o),
  .ovf_o   (ovf_o)
);

// File: tb/sim_nzcv_alu.sv
module sim_nzcv_alu;
  localparam int unsigned W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [1:0]   op;
  logic [W-1:0] res;
  logic         n_f, z_f, c_f, v_f;
  int           vectors = 0;
  int           miscompares = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  nzcv_alu #(.WIDTH(W)) u0 (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .neg_o(n_f), .zero_o(z_f), .carry_o(c_f), .ovf_o(v_f)
  );

  // Drive after a rising edge, sample at the next falling edge.
  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_v,
                       input logic [1:0] top, input string req);
    logic [W:0]   u;
    logic [W:0]   s;
    logic [W-1:0] er;
    logic         en, ez, ec, ev;
    @(posedge clk);
    a = ta; b = tb_v; op = top;
    u = {1'b0, ta} + (top[0] ? {1'b0, ~tb_v} + 1 : {1'b0, tb_v});
    if (top[0]) s = {ta[W-1], ta} - {tb_v[W-1], tb_v};
    else        s = {ta[W-1], ta} + {tb_v[W-1], tb_v};
    case (top)
      2'b10:   er = ta & tb_v;
      2'b11:   er = ta | tb_v;
      default: er = u[W-1:0];
    endcase
    en = er[W-1];
    ez = (er == '0);
    ec = !top[1] && u[W];
    ev = !top[1] && (s[W] != s[W-1]);
    @(negedge clk);
    vectors++;
    if (res !== er || {n_f, z_f, c_f, v_f} !== {en, ez, ec, ev}) begin
      miscompares++;
      $display("FAIL %s a=%h b=%h op=%b result/NZCV actual %h/%b expected %h/%b",
               req, ta, tb_v, top, res, {n_f, z_f, c_f, v_f}, er, {en, ez, ec, ev});
    end
  endtask

  task automatic t_idle_state;   // zero operands: R1 R5
    apply('0, '0, 2'b00, "R1 R5 zero inputs");
  endtask

  task automatic t_add_plain;
    apply(32'd5, 32'd7, 2'b00, "R1 small add");
    apply(32'h1234_5678, 32'h0101_0101, 2'b00, "R1 R4 mixed add");
    apply(32'hFFFF_FFFF, 32'd1, 2'b00, "R6 R5 full carry ripple");
    apply(32'hFFFF_FFF0, 32'h0000_0020, 2'b00, "R6 carry no overflow");
  endtask

  task automatic t_add_overflow;
    apply(32'h7FFF_FFFF, 32'd1, 2'b00, "R8 R4 positive overflow");
    apply(32'h8000_0000, 32'h8000_0000, 2'b00, "R8 R6 negative overflow with carry");
    apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b00, "R8 mixed signs no overflow");
  endtask

  task automatic t_sub;
    apply(32'd9, 32'd9, 2'b01, "R2 R5 R6 equal operands");
    apply(32'd3, 32'd10, 2'b01, "R2 R6 borrow clears carry");
    apply(32'd100, 32'd1, 2'b01, "R2 R6 no borrow");
    apply(32'h8000_0000, 32'd1, 2'b01, "R9 min minus one");
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b01, "R9 max minus minus-one");
    apply(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'b01, "R9 unlike signs no overflow");
    apply(32'h0000_0000, 32'h8000_0000, 2'b01, "R9 zero minus min");
  endtask

  task automatic t_logic;
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 2'b10, "R3 R4 and");
    apply(32'h0F0F_0F0F, 32'hF0F0_F0F0, 2'b10, "R3 R5 and to zero");
    apply(32'h00FF_0000, 32'h0000_00FF, 2'b11, "R3 or");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, "R7 and on carry operands");
    apply(32'h8000_0000, 32'h8000_0000, 2'b11, "R7 or on overflow operands");
    apply(32'h7FFF_FFFF, 32'd1, 2'b11, "R7 R4 or on positive overflow operands");
  endtask

  task automatic t_sweep;        // walking ones across all operations
    for (int i = 0; i < int'(W); i++) begin
      for (int k = 0; k < 4; k++) begin
        apply(32'h1 << i, 32'hFFFF_FFFF >> i, 2'(k), "R1 R2 R3 walk");
      end
    end
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    a = '0; b = '0; op = 2'b00;
    t_idle_state();
    t_add_plain();
    t_add_overflow();
    t_sub();
    t_logic();
    t_sweep();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      report();
    end
  end
endmodule